// File: doc/BRIEF.md
# Bidirectional Port with Edge-Captured Input

This block is a 12-bit general purpose I/O port. Each pin has its own direction bit. Pins marked as outputs drive the value of an output register. Pins marked as inputs can be read in one of two ways. The first is live, straight from the pins. The second is as a snapshot taken when a control input makes its active transition.

The control input passes through a synchronizer before its edge is detected. The active edge, rising or falling, is chosen by a configuration input. Each detected edge raises a flag meant for an interrupt controller.

A small register bus reaches three locations:

- a data register with handshake side effects;
- the direction register;
- an alias of the data register that has no side effects.

Any access through the handshake address clears the flag. An access through the alias address leaves the flag as it is. The latch enable and the edge selection come in as configuration inputs from a neighbouring control register.

Top module: `hsk_gpio_port`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: the direction register, the output register, the capture register and the edge flag. In particular pin_oe and pin_out read 0 and every pin is an input.
- R2: A write to address 1 loads the direction register. pin_oe equals that register, so a 1 makes the pin an output and a 0 makes it an input.
- R3: A write to address 0 or to address 2 loads the output register, which drives pin_out. For pins set as outputs, a read at address 0 or 2 returns the output register bit.
- R4: When latch_en is 0, a read at address 0 or 2 returns the current pin_in level on each input pin.
- R5: When latch_en is 1, a read at address 0 or 2 returns, on each input pin, the pin_in value captured at the most recent active edge. Later pin changes are not seen until the next active edge.
- R6: With edge_rising set to 1, only a 0-to-1 change of ctl_in is active. With edge_rising set to 0, only a 1-to-0 change is active. The inactive direction neither sets the flag nor captures data.
- R7: The edge flag rises on the SYNC_STAGES+1-th rising clock edge after ctl_in changes. With the default setting this is the third edge.
- R8: Any access (read or write) at address 0 clears the edge flag. If an active edge lands in the same cycle, the flag stays set.
- R9: Reads and writes at address 2 leave the edge flag unchanged.
- R10: A read at address 1 returns the direction register. A read at address 3 returns zero, and writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 alias) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| latch_en | input | 1 | Selects captured (1) or live (0) input reads |
| edge_rising | input | 1 | Active edge of ctl_in: 1 rising, 0 falling |
| ctl_in | input | 1 | Asynchronous control line that triggers capture |
| pin_in | input | DATA_W | Pin levels |
| pin_out | output | DATA_W | Output register value |
| pin_oe | output | DATA_W | Output enables, one per pin |
| edge_flag | output | 1 | Active-edge flag for the interrupt unit |

## Verification
The bench builds the block with its defaults: DATA_W of 12 and SYNC_STAGES of 2. The 12-bit width lets mixed direction masks place output and input pins next to each other in every nibble. The two-stage synchronizer makes the three-cycle flag latency observable: the flag is checked low after two edges and high after the third. That timing also lets a handshake read be placed exactly on the cycle in which an edge lands, which tests the set-over-clear priority.

// File: rtl/hsk_gpio_pkg.sv
package hsk_gpio_pkg;

   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADR_DATA  = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_DIR   = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_ALIAS = 2'd2;

   typedef struct packed {
      logic hs_access;   // any access at the handshake data address
      logic out_wr;      // write into the output register
      logic dir_wr;      // write into the direction register
      logic port_rd;     // read selects the port value
      logic dir_rd;      // read selects the direction register
   } bus_dec_t;

   function automatic bus_dec_t decode(input logic sel, input logic wr,
                                       input logic [ADDR_W-1:0] adr);
      bus_dec_t d;
      d.hs_access = sel && (adr == ADR_DATA);
      d.out_wr    = sel && wr && ((adr == ADR_DATA) || (adr == ADR_ALIAS));
      d.dir_wr    = sel && wr && (adr == ADR_DIR);
      d.port_rd   = (adr == ADR_DATA) || (adr == ADR_ALIAS);
      d.dir_rd    = (adr == ADR_DIR);
      return d;
   endfunction

endpackage

// File: rtl/hsk_edge_detect.sv
module hsk_edge_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   input  logic rise_sel,
   output logic hit
);

   logic synced;
   logic prev_q;

   generate
      if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk) begin
            if (rst) s_q <= 1'b0;
            else     s_q <= line_in;
         end
         assign synced = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk) begin
            if (rst) s_q <= '0;
            else     s_q <= {s_q[STAGES-2:0], line_in};
         end
         assign synced = s_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= synced;
   end

   assign hit = rise_sel ? (synced & ~prev_q) : (~synced & prev_q);

endmodule

// File: rtl/hsk_port_regs.sv
module hsk_port_regs #(
   parameter int unsigned WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dir_wr,
   input  logic             out_wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] out_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= '0;
         out_q <= '0;
      end else begin
         if (dir_wr) dir_q <= wdata;
         if (out_wr) out_q <= wdata;
      end
   end

endmodule

// File: rtl/hsk_capture.sv
module hsk_capture #(
   parameter int unsigned WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   input  logic             cap_en,
   input  logic             clr,
   input  logic [WIDTH-1:0] pins,
   output logic [WIDTH-1:0] snap_q,
   output logic             flag_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         snap_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (hit && cap_en) snap_q <= pins;
         // a fresh edge takes priority over a clearing access
         if (hit)      flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/hsk_read_mux.sv
module hsk_read_mux #(
   parameter int unsigned WIDTH = 12
) (
   input  logic             port_rd,
   input  logic             dir_rd,
   input  logic             use_snap,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] out_q,
   input  logic [WIDTH-1:0] snap_q,
   input  logic [WIDTH-1:0] pins,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] port_val;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign port_val[i] = dir_q[i] ? out_q[i]
                                       : (use_snap ? snap_q[i] : pins[i]);
      end
   endgenerate

   always_comb begin
      if (port_rd)     rdata = port_val;
      else if (dir_rd) rdata = dir_q;
      else             rdata = '0;
   end

endmodule

// File: rtl/hsk_gpio_port.sv
module hsk_gpio_port
   import hsk_gpio_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              latch_en,
   input  logic              edge_rising,
   input  logic              ctl_in,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe,
   output logic              edge_flag
);

   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
         $error("hsk_gpio_port: DATA_W must be within 1..64");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("hsk_gpio_port: SYNC_STAGES must be within 1..4");
      end
   endgenerate

   bus_dec_t          dec;
   logic              edge_hit;
   logic [DATA_W-1:0] dir_q;
   logic [DATA_W-1:0] out_q;
   logic [DATA_W-1:0] latch_val;

   assign dec = decode(bus_sel, bus_wr, bus_addr);

   hsk_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst      (rst),
      .line_in  (ctl_in),
      .rise_sel (edge_rising),
      .hit      (edge_hit)
   );

   hsk_port_regs #(.WIDTH(DATA_W)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .dir_wr (dec.dir_wr),
      .out_wr (dec.out_wr),
      .wdata  (bus_wdata),
      .dir_q  (dir_q),
      .out_q  (out_q)
   );

   hsk_capture #(.WIDTH(DATA_W)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .hit    (edge_hit),
      .cap_en (latch_en),
      .clr    (dec.hs_access),
      .pins   (pin_in),
      .snap_q (latch_val),
      .flag_q (edge_flag)
   );

   hsk_read_mux #(.WIDTH(DATA_W)) u_rmux (
      .port_rd  (dec.port_rd),
      .dir_rd   (dec.dir_rd),
      .use_snap (latch_en),
      .dir_q    (dir_q),
      .out_q    (out_q),
      .snap_q   (latch_val),
      .pins     (pin_in),
      .rdata    (bus_rdata)
   );

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/hsk_gpio_port_chk.sv
module hsk_gpio_port_chk #(
   parameter int unsigned DATA_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] pin_out,
   input logic [DATA_W-1:0] pin_oe,
   input logic              edge_flag,
   input logic              edge_hit,
   input logic [DATA_W-1:0] latch_val
);

   a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && bus_addr == 2'd1) |=> (pin_oe == $past(bus_wdata)));

   a_r3_out_write: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd2))
      |=> (pin_out == $past(bus_wdata)));

   a_r3_out_readback: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == 2'd0 || bus_addr == 2'd2)
      |-> (((bus_rdata ^ pin_out) & pin_oe) == '0));

   a_r5_latch_hold: assert property (@(posedge clk) disable iff (rst)
      !edge_hit |=> $stable(latch_val));

   a_r8_edge_sets: assert property (@(posedge clk) disable iff (rst)
      edge_hit |=> edge_flag);

   a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_addr == 2'd0 && !edge_hit) |=> !edge_flag);

   a_r9_alias_keeps: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_addr == 2'd2 && edge_flag) |=> edge_flag);

   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == 2'd3) |-> (bus_rdata == '0));

endmodule

bind hsk_gpio_port hsk_gpio_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .edge_flag (edge_flag),
   .edge_hit  (edge_hit),
   .latch_val (latch_val)
);

// File: tb/hsk_gpio_port_bench.sv
`timescale 1ns/1ps
module hsk_gpio_port_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [11:0] bus_wdata = '0;
   logic [11:0] bus_rdata;
   logic        latch_en = 1'b0;
   logic        edge_rising = 1'b1;
   logic        ctl_in = 1'b0;
   logic [11:0] pin_in = '0;
   logic [11:0] pin_out;
   logic [11:0] pin_oe;
   logic        edge_flag;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   hsk_gpio_port u_hsk_gpio_port (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .latch_en(latch_en), .edge_rising(edge_rising), .ctl_in(ctl_in),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .edge_flag(edge_flag)
   );

   // {direction, output value, pin levels, expected port read}
   localparam logic [47:0] VECS [0:5] = '{
      48'h000_000_ABC_ABC,
      48'hFFF_5A5_123_5A5,
      48'h0F0_3C3_F0F_FCF,
      48'hF00_9AB_456_956,
      48'h00F_FFF_000_00F,
      48'hAAA_555_FFF_555
   };

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [11:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [11:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [11:0] rd;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 pin_oe", pin_oe, 12'h000);
      chk("R1 pin_out", pin_out, 12'h000);
      chk("R1 edge_flag", {11'b0, edge_flag}, 12'h000);
      bus_read(2'd1, rd); chk("R1 dir read", rd, 12'h000);

      // table walk: R2, R3, R4 with mixed directions, latch disabled
      for (int i = 0; i < 6; i++) begin
         bus_write(2'd1, VECS[i][47:36]);
         bus_write(2'd0, VECS[i][35:24]);
         pin_in = VECS[i][23:12];
         chk("R2 pin_oe", pin_oe, VECS[i][47:36]);
         chk("R3 pin_out", pin_out, VECS[i][35:24]);
         bus_read(2'd0, rd); chk("R3/R4 port read", rd, VECS[i][11:0]);
         bus_read(2'd1, rd); chk("R10 dir read", rd, VECS[i][47:36]);
      end

      // R4 live read follows pins
      bus_write(2'd1, 12'h000);
      pin_in = 12'h111;
      bus_read(2'd2, rd); chk("R4 live read", rd, 12'h111);
      pin_in = 12'h222;
      bus_read(2'd0, rd); chk("R4 live follows", rd, 12'h222);

      // R7 latency and R5 capture, rising edge
      latch_en = 1'b1; edge_rising = 1'b1;
      pin_in = 12'h3A5;
      @(negedge clk); ctl_in = 1'b1;
      cycles(2); chk("R7 flag low after two edges", {11'b0, edge_flag}, 12'h000);
      cycles(1); chk("R7 flag high after third edge", {11'b0, edge_flag}, 12'h001);
      pin_in = 12'h0FF;
      bus_read(2'd2, rd); chk("R5 captured read", rd, 12'h3A5);
      chk("R9 alias read keeps flag", {11'b0, edge_flag}, 12'h001);
      bus_write(2'd2, 12'h6C6);
      chk("R3 alias write drives pins", pin_out, 12'h6C6);
      chk("R9 alias write keeps flag", {11'b0, edge_flag}, 12'h001);
      bus_read(2'd0, rd); chk("R5 captured via data address", rd, 12'h3A5);
      chk("R8 read clears flag", {11'b0, edge_flag}, 12'h000);

      // R6 falling edge ignored when rising selected
      pin_in = 12'h777;
      @(negedge clk); ctl_in = 1'b0;
      cycles(5); chk("R6 falling ignored flag", {11'b0, edge_flag}, 12'h000);
      bus_read(2'd2, rd); chk("R6 falling ignored capture", rd, 12'h3A5);
      edge_rising = 1'b0;
      @(negedge clk); ctl_in = 1'b1;
      cycles(5); chk("R6 rising ignored in falling mode", {11'b0, edge_flag}, 12'h000);
      @(negedge clk); ctl_in = 1'b0;
      cycles(5); chk("R6 falling edge sets flag", {11'b0, edge_flag}, 12'h001);
      bus_read(2'd2, rd); chk("R6 falling edge captures", rd, 12'h777);
      bus_write(2'd0, 12'h000);
      chk("R8 write clears flag", {11'b0, edge_flag}, 12'h000);

      // R8 edge landing on a clearing access keeps the flag
      pin_in = 12'h5E1;
      @(negedge clk); ctl_in = 1'b1;
      @(negedge clk); ctl_in = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
      @(negedge clk);
      bus_sel = 1'b0;
      chk("R8 set wins over clear", {11'b0, edge_flag}, 12'h001);
      bus_read(2'd2, rd); chk("R5 capture on set-wins edge", rd, 12'h5E1);

      // R10 unmapped address
      bus_read(2'd3, rd); chk("R10 unmapped read", rd, 12'h000);
      bus_write(2'd3, 12'hFFF);
      chk("R10 unmapped write pin_out", pin_out, 12'h000);
      chk("R10 unmapped write pin_oe", pin_oe, 12'h000);

      // R1 reset again clears everything
      bus_write(2'd1, 12'hFFF);
      bus_write(2'd0, 12'hABC);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R1 reset pin_oe", pin_oe, 12'h000);
      chk("R1 reset pin_out", pin_out, 12'h000);
      chk("R1 reset flag", {11'b0, edge_flag}, 12'h000);
      pin_in = 12'hFFF;
      bus_read(2'd2, rd); chk("R1 reset capture", rd, 12'h000);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule